// File: doc/BRIEF.md
# Basic Up-Counting Timer with Buffered Reload

This block is a small time base for a larger chip. A 16-bit counter counts upward at a rate set by a programmable divider. When it reaches its top value it wraps to zero and raises an update event. Software reaches every setting through a flat register interface. Writes land on the rising clock edge, and the read data follows the address in the same cycle. The counter, the divider setting and the top value can all be read and written while the timer runs.

The top value has two copies: the one software writes and reads, and the one the counter compares against. A buffering control bit picks how the copies relate. With the bit clear, the written value applies at once. With it set, the value moves into the active copy only on an update event. The divider setting is always buffered and takes effect at the next update event. An update event sets a sticky status flag. It can raise a level interrupt and a one-cycle DMA request, each with its own enable. It always drives a one-cycle trigger pulse for a downstream converter. Software can block updates from wrap-around, or force an update at any time.

Register map (3-bit address): 0 control (bit0 run, bit1 block-update, bit2 buffered reload), 1 request enables (bit0 interrupt, bit1 DMA), 2 status (bit0 update flag), 3 event generate (bit0 forces an update, reads 0), 4 counter, 5 divider, 6 top value.

Top module: `basic_timer`

## Requirements
- R1: After reset, the counter and the divider read 0, the top value reads 16'hFFFF, and the control, enable and status registers read 0. The interrupt, DMA and trigger outputs are low.
- R2: After the write that sets control bit0 (run), the counter still reads 0 in the following cycle and first reads 1 one cycle after that. With a divider value of 0 it then advances by one every cycle.
- R3: With divider value P active, the counter advances once every P+1 cycles. A written divider value reads back at once, but the count rate does not change until the next update event.
- R4: When the counter advances while equal to the active top value, it becomes 0 and an update event occurs. The trigger output (registered) is high for that one cycle and status bit0 becomes 1.
- R5: With control bit2 clear, a top value written while the timer runs takes effect at once.
- R6: With control bit2 set, a written top value reads back at once, but wrap-around keeps using the old value until an update event.
- R7: With control bit1 set, wrap-around still returns the counter to 0, but no update event occurs: no trigger pulse and no flag.
- R8: Writing 1 to bit0 of the event-generate register clears the counter and the divider count, loads the buffered values, and produces an update event even when control bit1 is set.
- R9: Status bit0 stays set until software writes 0 to it. Writing 1 leaves it unchanged.
- R10: The interrupt output equals status bit0 AND enable bit0. The DMA output is a one-cycle pulse on an update event only when enable bit1 is set.
- R11: A counter write while running takes effect at the write edge, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| upd_irq | output | 1 | Interrupt request (level) |
| upd_dma | output | 1 | DMA request pulse |
| trig_out | output | 1 | Trigger pulse to converter |

## Verification
The hardest case to reach from the ports is a deferred value: a buffered top value or divider that reads back already, but must not yet steer the counter. The stimulus rewrites these values in the middle of a count. It then checks the count on exact cycles on both sides of the next forced or natural update. This shows that the old value governs until the update and the new one after it. Blocked updates are reached by running into a wrap with control bit1 set, and then forcing an update on the same running timer.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_EVG  = 3'd3,
    A_CNT  = 3'd4,
    A_PSC  = 3'd5,
    A_RLD  = 3'd6
  } reg_addr_e;

  localparam int B_RUN  = 0;
  localparam int B_UDIS = 1;
  localparam int B_BUF  = 2;
  localparam int B_IRQE = 0;
  localparam int B_DMAE = 1;
endpackage

// File: rtl/timer_regs.sv
`timescale 1ns/1ps
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              uev,
  output logic              run,
  output logic              udis,
  output logic              arpe,
  output logic              irq_en,
  output logic              dma_en,
  output logic              swgen,
  output logic              cnt_wr,
  output logic              flag,
  output logic [CNT_W-1:0]  psc_pre,
  output logic [CNT_W-1:0]  psc_act,
  output logic [CNT_W-1:0]  arr_pre,
  output logic [CNT_W-1:0]  arr_act
);
  logic [2:0]       ctrl_q, ctrl_d;
  logic [1:0]       ien_q, ien_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] psc_pre_q, psc_pre_d, psc_act_q, psc_act_d;
  logic [CNT_W-1:0] arr_pre_q, arr_pre_d, arr_shd_q, arr_shd_d;

  logic wr_ctrl, wr_ien, wr_stat, wr_psc, wr_rld;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_ien  = wr_en && (addr == A_IEN);
    wr_stat = wr_en && (addr == A_STAT);
    wr_psc  = wr_en && (addr == A_PSC);
    wr_rld  = wr_en && (addr == A_RLD);
    swgen   = wr_en && (addr == A_EVG) && wdata[0];
    cnt_wr  = wr_en && (addr == A_CNT);
  end

  always_comb begin
    ctrl_d    = wr_ctrl ? wdata[2:0] : ctrl_q;
    ien_d     = wr_ien  ? wdata[1:0] : ien_q;
    psc_pre_d = wr_psc  ? wdata : psc_pre_q;
    arr_pre_d = wr_rld  ? wdata : arr_pre_q;
    psc_act_d = uev ? psc_pre_q : psc_act_q;
    arr_shd_d = (uev || !ctrl_q[B_BUF]) ? arr_pre_q : arr_shd_q;
    if (uev)
      flag_d = 1'b1;
    else if (wr_stat && !wdata[0])
      flag_d = 1'b0;
    else
      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      flag_q    <= 1'b0;
      psc_pre_q <= '0;
      psc_act_q <= '0;
      arr_pre_q <= '1;
      arr_shd_q <= '1;
    end else begin
      ctrl_q    <= ctrl_d;
      ien_q     <= ien_d;
      flag_q    <= flag_d;
      psc_pre_q <= psc_pre_d;
      psc_act_q <= psc_act_d;
      arr_pre_q <= arr_pre_d;
      arr_shd_q <= arr_shd_d;
    end
  end

  assign run     = ctrl_q[B_RUN];
  assign udis    = ctrl_q[B_UDIS];
  assign arpe    = ctrl_q[B_BUF];
  assign irq_en  = ien_q[B_IRQE];
  assign dma_en  = ien_q[B_DMAE];
  assign flag    = flag_q;
  assign psc_pre = psc_pre_q;
  assign psc_act = psc_act_q;
  assign arr_pre = arr_pre_q;
  assign arr_act = ctrl_q[B_BUF] ? arr_shd_q : arr_pre_q;
endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clear,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] pc_q, pc_d;

  always_comb begin
    tick = cnt_en && (pc_q == div);
    if (clear)
      pc_d = '0;
    else if (tick)
      pc_d = '0;
    else if (cnt_en)
      pc_d = pc_q + 1'b1;
    else
      pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
module timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             swgen,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ovf = tick && (cnt_q == top);
    if (swgen)
      cnt_d = '0;
    else if (load)
      cnt_d = load_val;
    else if (ovf)
      cnt_d = '0;
    else if (tick)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/basic_timer.sv
`timescale 1ns/1ps
module basic_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              upd_irq,
  output logic              upd_dma,
  output logic              trig_out
);
  logic rst_s1, rst_q;
  logic ctrl_run, ctrl_udis, ctrl_buf, irq_en, dma_en;
  logic sw_upd, cnt_wr, flag_q, cnt_en_q, tick, ovf, uev;
  logic trig_q, dma_q;
  logic [CNT_W-1:0] psc_pre, psc_act, arr_pre, arr_act, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .uev(uev), .run(ctrl_run), .udis(ctrl_udis),
    .arpe(ctrl_buf), .irq_en(irq_en), .dma_en(dma_en), .swgen(sw_upd),
    .cnt_wr(cnt_wr), .flag(flag_q), .psc_pre(psc_pre), .psc_act(psc_act),
    .arr_pre(arr_pre), .arr_act(arr_act)
  );

  timer_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_q), .cnt_en(cnt_en_q), .clear(uev),
    .div(psc_act), .tick(tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q), .tick(tick), .swgen(sw_upd),
    .load(cnt_wr), .load_val(bus_wdata), .top(arr_act),
    .cnt(cnt_q), .ovf(ovf)
  );

  assign uev = (ovf && !ctrl_udis) || sw_upd;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_en_q <= 1'b0;
      trig_q   <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      cnt_en_q <= ctrl_run;
      trig_q   <= uev;
      dma_q    <= uev && dma_en;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CNT_W-3){1'b0}}, ctrl_buf, ctrl_udis, ctrl_run};
      A_IEN:   bus_rdata = {{(CNT_W-2){1'b0}}, dma_en, irq_en};
      A_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
      A_CNT:   bus_rdata = cnt_q;
      A_PSC:   bus_rdata = psc_pre;
      A_RLD:   bus_rdata = arr_pre;
      default: bus_rdata = '0;
    endcase
  end

  assign upd_irq  = flag_q && irq_en;
  assign upd_dma  = dma_q;
  assign trig_out = trig_q;
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cnt_en,
  input logic             swgen,
  input logic             ovf,
  input logic             udis,
  input logic [CNT_W-1:0] cnt,
  input logic             trig,
  input logic             flag,
  input logic             dma
);
  p_enable_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en) |-> $past(run));

  p_swgen_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swgen |=> (cnt == '0) && trig);

  p_udis_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && udis && !swgen) |=> !trig);

  p_flag_on_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> flag);

  p_dma_with_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma |-> trig);
endmodule

bind basic_timer timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .run(ctrl_run), .cnt_en(cnt_en_q),
  .swgen(sw_upd), .ovf(ovf), .udis(ctrl_udis), .cnt(cnt_q),
  .trig(trig_q), .flag(flag_q), .dma(dma_q)
);

// File: tb/basic_timer_bench.sv
`timescale 1ns/1ps
module basic_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        upd_irq, upd_dma, trig_out;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  localparam logic [2:0] CTRL = 3'd0, IEN = 3'd1, STAT = 3'd2, EVG = 3'd3,
                         CNT = 3'd4, PSC = 3'd5, RLD = 3'd6;

  // {addr, write data, expected read-back}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {PSC,  16'h0007, 16'h0007},
    {RLD,  16'h1234, 16'h1234},
    {IEN,  16'h0003, 16'h0003},
    {CTRL, 16'h0006, 16'h0006},
    {CNT,  16'h0042, 16'h0042},
    {STAT, 16'h0001, 16'h0000}
  };

  always #10 clk = ~clk;

  basic_timer u_basic_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_irq(upd_irq),
    .upd_dma(upd_dma), .trig_out(trig_out)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=%h exp=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    chk_reg("R1 count", CNT, 16'h0000);
    chk_reg("R1 divider", PSC, 16'h0000);
    chk_reg("R1 top", RLD, 16'hFFFF);
    chk_reg("R1 ctrl", CTRL, 16'h0000);
    chk_reg("R1 stat", STAT, 16'h0000);
    check("R1 outputs", {13'b0, upd_irq, upd_dma, trig_out}, 16'h0000);

    // register access table (R9: writing 1 to status leaves it 0)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][34:32], VEC[i][31:16]);
      chk_reg("R11 R9 table readback", VEC[i][34:32], VEC[i][15:0]);
    end
    wr(CTRL, 0); wr(IEN, 0);

    // R2 enable latency
    wr(PSC, 0); wr(RLD, 16'hFFFF); wr(EVG, 1); wr(STAT, 0); wr(CTRL, 1);
    chk_reg("R2 count e+0", CNT, 0);
    cyc(1); chk_reg("R2 count e+1", CNT, 0);
    cyc(1); chk_reg("R2 count e+2", CNT, 1);
    cyc(1); chk_reg("R2 count e+3", CNT, 2);

    // R4 wrap at top 3
    wr(CTRL, 0); wr(RLD, 3); wr(EVG, 1); wr(STAT, 0); wr(CTRL, 1);
    cyc(4);
    chk_reg("R4 before wrap", CNT, 3);
    check("R4 no trig yet", {15'b0, trig_out}, 0);
    cyc(1);
    chk_reg("R4 wrapped", CNT, 0);
    check("R4 trig", {15'b0, trig_out}, 1);
    chk_reg("R4 flag", STAT, 1);
    cyc(1);
    check("R4 trig one cycle", {15'b0, trig_out}, 0);

    // R5 immediate top value
    wr(CTRL, 0); wr(RLD, 16'hFFFF); wr(EVG, 1); wr(CTRL, 1); wr(RLD, 5);
    cyc(5); chk_reg("R5 reached 5", CNT, 5);
    cyc(1); chk_reg("R5 wrap at new top", CNT, 0);
    check("R5 trig", {15'b0, trig_out}, 1);

    // R3 divide by 3, deferred divider change
    wr(CTRL, 0); wr(PSC, 2); wr(RLD, 16'hFFFF); wr(EVG, 1); wr(CTRL, 1);
    cyc(3); chk_reg("R3 count e+3", CNT, 0);
    cyc(1); chk_reg("R3 count e+4", CNT, 1);
    cyc(2); chk_reg("R3 count e+6", CNT, 1);
    cyc(1); chk_reg("R3 count e+7", CNT, 2);
    wr(PSC, 0);
    chk_reg("R3 divider readback", PSC, 0);
    cyc(1); chk_reg("R3 old rate kept", CNT, 2);
    cyc(1); chk_reg("R3 old rate step", CNT, 3);
    wr(EVG, 1);
    chk_reg("R3 cleared by update", CNT, 0);
    cyc(1); chk_reg("R3 new rate", CNT, 1);

    // R6 buffered top value
    wr(CTRL, 0); wr(RLD, 16'hFFFF); wr(CTRL, 4); wr(EVG, 1); wr(RLD, 2);
    chk_reg("R6 readback preload", RLD, 2);
    wr(CTRL, 5);
    cyc(4); chk_reg("R6 old top used", CNT, 3);
    wr(CTRL, 4); wr(EVG, 1); wr(STAT, 0); wr(CTRL, 5);
    cyc(3); chk_reg("R6 new top count", CNT, 2);
    cyc(1); chk_reg("R6 wrap at new top", CNT, 0);
    check("R6 trig", {15'b0, trig_out}, 1);

    // R7 blocked update
    wr(CTRL, 0); wr(RLD, 2); wr(EVG, 1); wr(STAT, 0); wr(CTRL, 3);
    cyc(3); chk_reg("R7 count 2", CNT, 2);
    cyc(1); chk_reg("R7 wraps", CNT, 0);
    check("R7 no trig", {15'b0, trig_out}, 0);
    chk_reg("R7 no flag", STAT, 0);

    // R8 forced update despite block
    cyc(1);
    wr(EVG, 1);
    chk_reg("R8 count cleared", CNT, 0);
    check("R8 trig", {15'b0, trig_out}, 1);
    chk_reg("R8 flag", STAT, 1);

    // R9 sticky flag
    wr(STAT, 1); chk_reg("R9 write 1 keeps", STAT, 1);
    wr(STAT, 0); chk_reg("R9 write 0 clears", STAT, 0);

    // R10 request gating
    wr(IEN, 1); wr(EVG, 1);
    check("R10 irq on", {15'b0, upd_irq}, 1);
    check("R10 dma off", {15'b0, upd_dma}, 0);
    wr(STAT, 0);
    check("R10 irq off", {15'b0, upd_irq}, 0);
    wr(IEN, 2); wr(EVG, 1);
    check("R10 dma pulse", {15'b0, upd_dma}, 1);
    check("R10 irq masked", {15'b0, upd_irq}, 0);
    cyc(1);
    check("R10 dma one cycle", {15'b0, upd_dma}, 0);
    wr(IEN, 0); wr(EVG, 1);
    check("R10 dma gated", {15'b0, upd_dma}, 0);
    check("R10 trig ungated", {15'b0, trig_out}, 1);

    // R11 counter write while running
    wr(CTRL, 0); wr(RLD, 16'hFFFF); wr(EVG, 1); wr(CTRL, 1);
    cyc(3);
    wr(CNT, 100);
    chk_reg("R11 written", CNT, 100);
    cyc(1); chk_reg("R11 continues", CNT, 101);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule